// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control engine for a single DMA channel. Software loads a remaining-item count, a peripheral-side address and a memory-side address, then writes a control word whose low bit enables the channel. While enabled, the sequencer presents one bus request per item on a valid/ready interface. Each request carries a source address, a destination address and both item sizes. Each accepted item lowers the count and advances whichever addresses are set to increment.

The sequencer pulses a half-way event, a completion event and an error event. In circular mode it reloads the count and both addresses from the values captured when the channel was enabled, and keeps running without software help. In normal mode it drops its own enable at completion. A bus error also drops the enable. The live item count and the matching byte count are always visible, so software can stop the channel, retarget the memory address and restart it.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the control word reads 0, the count reads 0, the byte count reads 0, no request is valid and no event is raised.
- R2: Writing the control word with bit 0 set while either size field (bits [9:8] peripheral, bits [11:10] memory) holds the reserved code 3 leaves the channel disabled, issues no request and pulses err_o on the next cycle.
- R3: Writing the control word with bit 0 set while the loaded count is 0 leaves the channel disabled and pulses err_o on the next cycle.
- R4: A request is valid from the cycle after a legal enable. Control bit 4 picks the direction: 1 means the source is the memory address and the destination is the peripheral address; 0 means the reverse.
- R5: After each accepted item, the peripheral address advances by its item size in bytes when bit 6 is set, and the memory address does the same when bit 7 is set. Size code 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. An address whose bit is clear does not move.
- R6: The count drops by one for each accepted item (valid and ready high, no error). It holds while ready is low.
- R7: bytes_left_o equals the live count shifted left by the peripheral size code.
- R8: half_o pulses in the cycle after the accepted item that leaves the count equal to half the count captured at enable (rounded down).
- R9: When an accepted item brings the count to zero, done_o pulses the next cycle. With bit 5 clear, the channel disables itself and stops requesting.
- R10: With bit 5 set, the item that completes the buffer reloads the count and both addresses from their values captured at enable. The channel stays enabled and done_o still pulses.
- R11: A request accepted with req_err_i high clears the enable, pulses err_o and leaves the count and addresses unchanged.
- R12: Writing the control word with bit 0 clear stops requests and keeps the count. A new memory address followed by a re-enable resumes from the kept count at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_i | input | 16 | Control word write data |
| cnt_wr_i | input | 1 | Item count write strobe |
| cnt_i | input | CNT_W | Item count write data |
| paddr_wr_i | input | 1 | Peripheral address write strobe |
| paddr_i | input | ADDR_W | Peripheral address write data |
| maddr_wr_i | input | 1 | Memory address write strobe |
| maddr_i | input | ADDR_W | Memory address write data |
| cfg_o | output | 16 | Live control word, bit 0 is the live enable |
| cnt_o | output | CNT_W | Live remaining item count |
| bytes_left_o | output | CNT_W+2 | Remaining bytes at peripheral item size |
| req_valid_o | output | 1 | Item request valid |
| req_ready_i | input | 1 | Item request accepted |
| req_err_i | input | 1 | Bus error on the accepted item |
| req_src_addr_o | output | ADDR_W | Source address of the item |
| req_dst_addr_o | output | ADDR_W | Destination address of the item |
| req_psize_o | output | 2 | Peripheral item size code |
| req_msize_o | output | 2 | Memory item size code |
| half_o | output | 1 | Half-way event pulse |
| done_o | output | 1 | Completion event pulse |
| err_o | output | 1 | Error event pulse |

## Verification
A vector table covers four control words that differ in direction, increment bits and size codes. Each row checks the first request's addresses and the addresses after one item. This separates a swapped source and destination, an address that moves when it should stay fixed, and a step taken from the wrong size field. Directed runs then follow a full four-item buffer with stalls, to pin the half-way point and self-disable. A two-item circular buffer shows that both addresses and the count reload. Further runs check an erroring beat, enables with reserved sizes or a zero count, and a stop, retarget and resume.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int CFG_W     = 16;
  localparam int B_EN      = 0;
  localparam int B_DIR     = 4;
  localparam int B_CIRC    = 5;
  localparam int B_PINC    = 6;
  localparam int B_MINC    = 7;
  localparam int B_PSIZE_L = 8;
  localparam int B_MSIZE_L = 10;
  localparam logic [1:0] SIZE_RSVD = 2'd3;
endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              latch_i,
  input  logic              step_i,
  input  logic              inc_i,
  input  logic [1:0]        size_i,
  input  logic              reload_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, start_q, stride;

  assign stride = inc_i ? (ADDR_W'(1) << size_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      start_q <= '0;
    end else begin
      if (latch_i) start_q <= addr_q;
      if (wr_i)          addr_q <= wdata_i;
      else if (reload_i) addr_q <= start_q;
      else if (step_i)   addr_q <= addr_q + stride;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_seq_count.sv
module dma_seq_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             latch_i,
  input  logic             dec_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             half_hit_o
);
  logic [CNT_W-1:0] cnt_q, start_q, cnt_m1;

  assign cnt_m1     = cnt_q - CNT_W'(1);
  assign last_o     = (cnt_q == CNT_W'(1));
  assign half_hit_o = (cnt_m1 == (start_q >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      start_q <= '0;
    end else begin
      if (latch_i) start_q <= cnt_q;
      if (wr_i)          cnt_q <= wdata_i;
      else if (reload_i) cnt_q <= start_q;
      else if (dec_i)    cnt_q <= cnt_m1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              cnt_wr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              paddr_wr_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic              maddr_wr_i,
  input  logic [ADDR_W-1:0] maddr_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W+1:0]  bytes_left_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  input  logic              req_err_i,
  output logic [ADDR_W-1:0] req_src_addr_o,
  output logic [ADDR_W-1:0] req_dst_addr_o,
  output logic [1:0]        req_psize_o,
  output logic [1:0]        req_msize_o,
  output logic              half_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int BYTES_W = CNT_W + 2;

  logic [CFG_W-1:0]  cfg_q;
  logic              en_q, half_q, done_q, err_q;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] paddr, maddr;
  logic [1:0]        psize, msize;
  logic              en_req, wr_bad, bad_start, start_go;
  logic              xfer, bus_err, ok, last, half_hit, reload, step;

  assign en_q  = cfg_q[B_EN];
  assign psize = cfg_q[B_PSIZE_L +: 2];
  assign msize = cfg_q[B_MSIZE_L +: 2];

  // enable-time validation uses the sizes being written
  assign wr_bad    = (cfg_i[B_PSIZE_L +: 2] == SIZE_RSVD) ||
                     (cfg_i[B_MSIZE_L +: 2] == SIZE_RSVD) || (cnt == '0);
  assign en_req    = cfg_wr_i & cfg_i[B_EN];
  assign bad_start = en_req & wr_bad;
  assign start_go  = en_req & ~wr_bad & ~en_q;

  assign xfer    = en_q & req_ready_i;
  assign bus_err = xfer & req_err_i;
  assign ok      = xfer & ~req_err_i;
  assign reload  = ok & last & cfg_q[B_CIRC];
  assign step    = ok & ~reload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      half_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (cfg_wr_i) begin
        cfg_q          <= cfg_i;
        cfg_q[B_EN]    <= cfg_i[B_EN] & ~wr_bad;
      end else if (bus_err || (ok && last && !cfg_q[B_CIRC])) begin
        cfg_q[B_EN]    <= 1'b0;
      end
      half_q <= ok & half_hit;
      done_q <= ok & last;
      err_q  <= bus_err | bad_start;
    end
  end

  dma_seq_count #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cnt_wr_i),
    .wdata_i    (cnt_i),
    .latch_i    (start_go),
    .dec_i      (step),
    .reload_i   (reload),
    .cnt_o      (cnt),
    .last_o     (last),
    .half_hit_o (half_hit)
  );

  dma_seq_addr #(.ADDR_W(ADDR_W)) u_paddr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (paddr_wr_i),
    .wdata_i  (paddr_i),
    .latch_i  (start_go),
    .step_i   (step),
    .inc_i    (cfg_q[B_PINC]),
    .size_i   (psize),
    .reload_i (reload),
    .addr_o   (paddr)
  );

  dma_seq_addr #(.ADDR_W(ADDR_W)) u_maddr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (maddr_wr_i),
    .wdata_i  (maddr_i),
    .latch_i  (start_go),
    .step_i   (step),
    .inc_i    (cfg_q[B_MINC]),
    .size_i   (msize),
    .reload_i (reload),
    .addr_o   (maddr)
  );

  assign cfg_o          = cfg_q;
  assign cnt_o          = cnt;
  assign bytes_left_o   = BYTES_W'(cnt) << psize;
  assign req_valid_o    = en_q;
  assign req_src_addr_o = cfg_q[B_DIR] ? maddr : paddr;
  assign req_dst_addr_o = cfg_q[B_DIR] ? paddr : maddr;
  assign req_psize_o    = psize;
  assign req_msize_o    = msize;
  assign half_o         = half_q;
  assign done_o         = done_q;
  assign err_o          = err_q;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_wr_i,
  input logic [15:0]       cfg_i,
  input logic              cnt_wr_i,
  input logic              paddr_wr_i,
  input logic              maddr_wr_i,
  input logic [15:0]       cfg_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              req_err_i,
  input logic [ADDR_W-1:0] req_src_addr_o,
  input logic              done_o,
  input logic              err_o
);
  logic quiet;
  assign quiet = !cfg_wr_i && !cnt_wr_i && !paddr_wr_i && !maddr_wr_i;

  p_bad_size_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && cfg_i[0] && cfg_i[9:8] == 2'd3 |=> !req_valid_o && err_o);

  p_count_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && req_valid_o && req_ready_i && !req_err_i && cnt_o > 1
    |=> cnt_o == $past(cnt_o) - 1);

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && req_valid_o && !req_ready_i |=> $stable(cnt_o) && $stable(req_src_addr_o));

  p_normal_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && req_valid_o && req_ready_i && !req_err_i && cnt_o == 1 && !cfg_o[5]
    |=> done_o && !req_valid_o);

  p_circ_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && req_valid_o && req_ready_i && !req_err_i && cnt_o == 1 && cfg_o[5]
    |=> done_o && req_valid_o && cnt_o != 0);

  p_bus_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && req_valid_o && req_ready_i && req_err_i
    |=> err_o && !req_valid_o && $stable(cnt_o));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_wr_i       (cfg_wr_i),
  .cfg_i          (cfg_i),
  .cnt_wr_i       (cnt_wr_i),
  .paddr_wr_i     (paddr_wr_i),
  .maddr_wr_i     (maddr_wr_i),
  .cfg_o          (cfg_o),
  .cnt_o          (cnt_o),
  .req_valid_o    (req_valid_o),
  .req_ready_i    (req_ready_i),
  .req_err_i      (req_err_i),
  .req_src_addr_o (req_src_addr_o),
  .done_o         (done_o),
  .err_o          (err_o)
);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 32;

  typedef struct packed {
    logic [15:0] cfg;
    logic [31:0] pa, ma, s0, d0, s1, d1;
    logic [17:0] b1;
  } vec_t;

  // count 4, one item accepted before the second address check
  localparam vec_t VECS [4] = '{
    '{16'h0A81, 32'h1000, 32'h2000, 32'h1000, 32'h2000, 32'h1000, 32'h2004, 18'd12},
    '{16'h0091, 32'h4000, 32'h3000, 32'h3000, 32'h4000, 32'h3001, 32'h4000, 18'd3},
    '{16'h05C1, 32'h0010, 32'h0020, 32'h0010, 32'h0020, 32'h0012, 32'h0022, 18'd6},
    '{16'h0251, 32'h0600, 32'h0500, 32'h0500, 32'h0600, 32'h0500, 32'h0604, 18'd12}
  };

  logic clk = 0, rst_ni = 0;
  logic cfg_wr = 0, cnt_wr = 0, pa_wr = 0, ma_wr = 0;
  logic [15:0] cfg_d = 0;
  logic [CNT_W-1:0] cnt_d = 0;
  logic [ADDR_W-1:0] pa_d = 0, ma_d = 0;
  logic ready = 0, berr = 0;
  logic [15:0] cfg_o;
  logic [CNT_W-1:0] cnt_o;
  logic [CNT_W+1:0] bytes_o;
  logic valid, half, done, err;
  logic [ADDR_W-1:0] src, dst;
  logic [1:0] psz, msz;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dma_chan_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_wr_i(cfg_wr), .cfg_i(cfg_d), .cnt_wr_i(cnt_wr), .cnt_i(cnt_d),
    .paddr_wr_i(pa_wr), .paddr_i(pa_d), .maddr_wr_i(ma_wr), .maddr_i(ma_d),
    .cfg_o(cfg_o), .cnt_o(cnt_o), .bytes_left_o(bytes_o),
    .req_valid_o(valid), .req_ready_i(ready), .req_err_i(berr),
    .req_src_addr_o(src), .req_dst_addr_o(dst), .req_psize_o(psz), .req_msize_o(msz),
    .half_o(half), .done_o(done), .err_o(err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic prog(input logic [15:0] c, input logic [31:0] p, input logic [31:0] m);
    cnt_d = c; pa_d = p; ma_d = m; cnt_wr = 1; pa_wr = 1; ma_wr = 1;
    @(negedge clk);
    cnt_wr = 0; pa_wr = 0; ma_wr = 0;
  endtask

  task automatic wcfg(input logic [15:0] v);
    cfg_d = v; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg", cfg_o, 0);
    chk("R1 cnt", cnt_o, 0);
    chk("R1 bytes", bytes_o, 0);
    chk("R1 valid", valid, 0);
    chk("R1 events", {half, done, err}, 0);

    // R4 R5 R6 R7 vector walk
    for (int i = 0; i < 4; i++) begin
      prog(16'd4, VECS[i].pa, VECS[i].ma);
      wcfg(VECS[i].cfg);
      chk("R4 valid", valid, 1);
      chk("R4 src", src, VECS[i].s0);
      chk("R4 dst", dst, VECS[i].d0);
      ready = 1;
      @(negedge clk);
      ready = 0;
      chk("R5 src step", src, VECS[i].s1);
      chk("R5 dst step", dst, VECS[i].d1);
      chk("R6 cnt", cnt_o, 3);
      chk("R7 bytes", bytes_o, VECS[i].b1);
      wcfg(VECS[i].cfg & 16'hFFFE);
    end

    // R2 reserved size
    prog(16'd4, 32'h1000, 32'h2000);
    wcfg(16'h0301);
    chk("R2 err", err, 1);
    chk("R2 valid", valid, 0);
    chk("R2 en", cfg_o[0], 0);
    @(negedge clk);
    chk("R2 pulse", err, 0);

    // R3 zero count
    prog(16'd0, 32'h1000, 32'h2000);
    wcfg(16'h0A81);
    chk("R3 err", err, 1);
    chk("R3 valid", valid, 0);

    // R6 R8 R9 full normal buffer with stalls
    prog(16'd4, 32'h1000, 32'h2000);
    wcfg(16'h0A81);
    repeat (2) @(negedge clk);
    chk("R6 stall cnt", cnt_o, 4);
    chk("R6 stall src", src, 32'h1000);
    ready = 1;
    @(negedge clk);
    chk("R6 cnt3", cnt_o, 3);
    chk("R8 no half", half, 0);
    @(negedge clk);
    chk("R8 half", half, 1);
    @(negedge clk);
    chk("R8 half pulse", half, 0);
    @(negedge clk);
    ready = 0;
    chk("R9 done", done, 1);
    chk("R9 cnt0", cnt_o, 0);
    chk("R9 valid off", valid, 0);
    chk("R9 en off", cfg_o[0], 0);

    // R10 circular with both increments
    prog(16'd2, 32'h1000, 32'h2000);
    wcfg(16'h0AE1);
    ready = 1;
    @(negedge clk);
    chk("R10 src mid", src, 32'h1004);
    chk("R8 circ half", half, 1);
    @(negedge clk);
    ready = 0;
    chk("R10 done", done, 1);
    chk("R10 cnt reload", cnt_o, 2);
    chk("R10 src reload", src, 32'h1000);
    chk("R10 dst reload", dst, 32'h2000);
    chk("R10 still on", valid, 1);
    wcfg(16'h0AE0);

    // R11 bus error
    prog(16'd3, 32'h1000, 32'h2000);
    wcfg(16'h0A81);
    ready = 1; berr = 1;
    @(negedge clk);
    ready = 0; berr = 0;
    chk("R11 err", err, 1);
    chk("R11 valid", valid, 0);
    chk("R11 cnt", cnt_o, 3);
    chk("R11 dst", dst, 32'h2000);

    // R12 stop, retarget, resume
    prog(16'd4, 32'h1000, 32'h2000);
    wcfg(16'h0A81);
    ready = 1;
    @(negedge clk);
    ready = 0;
    wcfg(16'h0A80);
    ready = 1;
    @(negedge clk);
    ready = 0;
    chk("R12 stopped", valid, 0);
    chk("R12 cnt kept", cnt_o, 3);
    ma_d = 32'h8000; ma_wr = 1;
    @(negedge clk);
    ma_wr = 0;
    wcfg(16'h0A81);
    chk("R12 resume dst", dst, 32'h8000);
    chk("R12 resume valid", valid, 1);
    ready = 1;
    @(negedge clk);
    ready = 0;
    chk("R12 cnt", cnt_o, 2);
    chk("R12 dst step", dst, 32'h8004);

    summary();
  end
endmodule